// File: doc/BRIEF.md
# Synthesizer VCO Calibration Readback Sequencer

This block learns the VCO settings that a serially programmed frequency synthesizer picks for one target frequency. A request carries the target's frequency-setting word for the device's register 0. The block then programs the synthesizer over a three-wire bus (serial clock, serial data, load enable) so that three things hold:

- the device reports calibration progress on its multiplexed output pin;
- automatic calibration is enabled;
- the calibration is started.

The block watches that pin until calibration completes. It then switches the pin to readback, shifts out the chosen core and band, reselects the read source, and shifts out the bias code. The three values are offered on a valid/ready result port so that a controller can build a per-device lookup table one frequency at a time.

The request port takes one word when `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle. The result port holds `res_valid` and all result fields steady until `res_ready` is seen high. That handshake is the done strobe. A stalled consumer keeps the block from taking a new request.

All serial timing is derived from one half-period count, `HALF_CYC` system clocks. Every serial clock level and every load-enable setup or hold lasts at least that long.

Top module: `vco_cal_reader`

## Requirements
- R1: Out of reset `spi_le` and `spi_sclk` are low, `req_ready` is high and `res_valid` is low. Whenever the block is idle, both bus lines are low.
- R2: After a request, four configuration words are written in this order, each 32 bits with the register address in bits [3:0]:
  - address 10 with value 001 at bits [28:26];
  - address 7 with value 110 at bits [14:12];
  - address 4 with value 111 at bits [29:27];
  - address 0, equal to the request word with bit 21 forced to 1 and bits [3:0] forced to 0.

  Each word is shifted MSB first on rising serial clock edges with `spi_le` low, and is latched by a following high pulse on `spi_le`.
- R3: After the fourth word, nothing further is written until the synchronized `mux_in` is high.
- R4: Once `mux_in` is high, address 7 is rewritten with 111 at bits [14:12].
- R5: The first readback holds `spi_le` high for 12 serial clocks and samples `mux_in` on each falling edge, MSB first. `res_core` takes bits [11:9], whose codes are 001 for core D, 010 for C, 011 for B and 100 for A. `res_band` takes bits [7:0]. Bit 8 is ignored.
- R6: After the first readback, address 10 is rewritten with 011 at bits [28:26]. A second 12-bit readback follows, and `res_bias` takes its bits [3:0]. Bits [11:4] are ignored.
- R7: `res_valid` and the result fields stay stable until `res_ready` is high. The block then returns to idle with `req_ready` high.
- R8: If `mux_in` stays low for `TIMEOUT_CYC` cycles of waiting, the block skips the rewrite and both readbacks. It presents `res_timeout` = 1 with core, band and bias all zero.
- R9: Every serial clock high or low level lasts at least `HALF_CYC` system cycles. During a readback, the first rising serial clock comes at least `HALF_CYC` cycles after `spi_le` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Learn request offered |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_r0_word | input | 32 | Frequency word for the device's register 0 |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Consumer takes result |
| res_core | output | 3 | Core code read back |
| res_band | output | 8 | Band read back |
| res_bias | output | 4 | Bias code read back |
| res_timeout | output | 1 | Calibration never completed |
| spi_sclk | output | 1 | Serial clock to the device |
| spi_sdata | output | 1 | Serial data to the device |
| spi_le | output | 1 | Load enable to the device |
| mux_in | input | 1 | Device multiplexed output pin |

## Verification
The assertions check several things on every cycle:

- both bus lines are low whenever the block is idle or waiting for calibration;
- the result stays stable while it is stalled;
- a timed-out result carries zero fields;
- no serial clock level is shorter than the half period.

Only the bench's device model can show that the words arrive in the right order with the right field contents, and that the bits are sampled on the correct edge and assembled MSB first. The same holds for ignoring the don't-care bits, for holding the rewrite and readbacks back until the calibration flag rises, and for the timeout path skipping them entirely. The bench sweeps every core code across a spread of bands and bias codes, with varied calibration delays and consumer stalls.

// File: rtl/vco_cal_pkg.sv
package vco_cal_pkg;

  localparam int WORD_W = 32;
  localparam int RB_W   = 12;

  localparam logic [3:0] ADDR_R0  = 4'd0;
  localparam logic [3:0] ADDR_MUX = 4'd4;
  localparam logic [3:0] ADDR_RB  = 4'd7;
  localparam logic [3:0] ADDR_VCO = 4'd10;

  localparam int RDSEL_LSB   = 26;
  localparam int RBSEL_LSB   = 12;
  localparam int MUXSEL_LSB  = 27;
  localparam int AUTOCAL_BIT = 21;

  localparam logic [2:0] RDSEL_CORE_BAND = 3'b001;
  localparam logic [2:0] RDSEL_BIAS      = 3'b011;
  localparam logic [2:0] RBSEL_CAL_DONE  = 3'b110;
  localparam logic [2:0] RBSEL_DATA      = 3'b111;
  localparam logic [2:0] MUXSEL_READBACK = 3'b111;

  typedef enum logic [3:0] {
    E_IDLE, E_WLO, E_WHI, E_WLE, E_WEND, E_RSET, E_RHI, E_RLO, E_REND
  } eng_state_t;

  typedef enum logic [3:0] {
    S_IDLE, S_W10A, S_W7A, S_W4, S_W0, S_WAIT, S_W7B, S_RD_CB, S_W10B,
    S_RD_BIAS, S_OUT
  } seq_state_t;

  function automatic logic [WORD_W-1:0] cfg_word(input logic [3:0] addr,
                                                 input int lsb,
                                                 input logic [2:0] val);
    return (WORD_W'(val) << lsb) | WORD_W'(addr);
  endfunction

endpackage

// File: rtl/vcr_half_timer.sv
module vcr_half_timer #(
  parameter int HALF_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = $clog2(HALF_CYC + 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(HALF_CYC - 1)) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/vcr_serial_engine.sv
module vcr_serial_engine
  import vco_cal_pkg::*;
#(
  parameter int HALF_CYC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_wr,
  input  logic              start_rd,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              mux_s,
  output logic              done,
  output logic [RB_W-1:0]   rd_word,
  output logic              sclk,
  output logic              sdata,
  output logic              le
);
  localparam int BW = $clog2(WORD_W);

  eng_state_t        st;
  logic [WORD_W-1:0] sh;
  logic [BW-1:0]     bitcnt;
  logic              tick;
  logic              restart;

  assign restart = (st == E_IDLE) && (start_wr || start_rd);
  assign sdata   = sh[WORD_W-1];

  vcr_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= E_IDLE;
      sh      <= '0;
      bitcnt  <= '0;
      rd_word <= '0;
      sclk    <= 1'b0;
      le      <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        E_IDLE: begin
          if (start_wr) begin
            sh     <= wr_word;
            bitcnt <= '0;
            sclk   <= 1'b0;
            le     <= 1'b0;
            st     <= E_WLO;
          end else if (start_rd) begin
            bitcnt <= '0;
            sclk   <= 1'b0;
            le     <= 1'b1;
            st     <= E_RSET;
          end
        end
        E_WLO: if (tick) begin
          sclk <= 1'b1;
          st   <= E_WHI;
        end
        E_WHI: if (tick) begin
          sclk <= 1'b0;
          if (bitcnt == BW'(WORD_W - 1)) begin
            le <= 1'b1;
            st <= E_WLE;
          end else begin
            bitcnt <= bitcnt + 1'b1;
            sh     <= sh << 1;
            st     <= E_WLO;
          end
        end
        E_WLE: if (tick) begin
          le <= 1'b0;
          st <= E_WEND;
        end
        E_WEND: if (tick) begin
          done <= 1'b1;
          st   <= E_IDLE;
        end
        E_RSET: if (tick) begin
          sclk <= 1'b1;
          st   <= E_RHI;
        end
        E_RHI: if (tick) begin
          sclk    <= 1'b0;
          rd_word <= {rd_word[RB_W-2:0], mux_s};
          st      <= E_RLO;
        end
        E_RLO: if (tick) begin
          if (bitcnt == BW'(RB_W - 1)) begin
            st <= E_REND;
          end else begin
            bitcnt <= bitcnt + 1'b1;
            sclk   <= 1'b1;
            st     <= E_RHI;
          end
        end
        E_REND: if (tick) begin
          le   <= 1'b0;
          done <= 1'b1;
          st   <= E_IDLE;
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vcr_seq_fsm.sv
module vcr_seq_fsm
  import vco_cal_pkg::*;
#(
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WORD_W-1:0] req_r0_word,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [2:0]        res_core,
  output logic [7:0]        res_band,
  output logic [3:0]        res_bias,
  output logic              res_timeout,
  input  logic              mux_s,
  input  logic              eng_done,
  input  logic [RB_W-1:0]   rd_word,
  output logic              start_wr,
  output logic              start_rd,
  output logic [WORD_W-1:0] wr_word,
  output logic              cal_wait
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [WORD_W-1:0] R0_FORCE_SET = WORD_W'(1) << AUTOCAL_BIT;
  localparam logic [WORD_W-1:0] R0_FORCE_CLR = WORD_W'(4'hF);

  seq_state_t        st;
  logic              launched;
  logic [TW-1:0]     to_cnt;
  logic [WORD_W-1:0] r0_q;
  logic              is_wr;
  logic              is_rd;
  logic              unused_rb8;

  assign unused_rb8 = rd_word[8];
  assign req_ready  = (st == S_IDLE);
  assign res_valid  = (st == S_OUT);
  assign cal_wait   = (st == S_WAIT);
  assign is_rd      = (st == S_RD_CB) || (st == S_RD_BIAS);
  assign is_wr      = (st == S_W10A) || (st == S_W7A) || (st == S_W4) ||
                      (st == S_W0) || (st == S_W7B) || (st == S_W10B);
  assign start_wr   = is_wr && !launched;
  assign start_rd   = is_rd && !launched;

  always_comb begin
    case (st)
      S_W10A:  wr_word = cfg_word(ADDR_VCO, RDSEL_LSB, RDSEL_CORE_BAND);
      S_W7A:   wr_word = cfg_word(ADDR_RB, RBSEL_LSB, RBSEL_CAL_DONE);
      S_W4:    wr_word = cfg_word(ADDR_MUX, MUXSEL_LSB, MUXSEL_READBACK);
      S_W0:    wr_word = r0_q;
      S_W7B:   wr_word = cfg_word(ADDR_RB, RBSEL_LSB, RBSEL_DATA);
      S_W10B:  wr_word = cfg_word(ADDR_VCO, RDSEL_LSB, RDSEL_BIAS);
      default: wr_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      launched    <= 1'b0;
      to_cnt      <= '0;
      r0_q        <= '0;
      res_core    <= '0;
      res_band    <= '0;
      res_bias    <= '0;
      res_timeout <= 1'b0;
    end else begin
      if ((is_wr || is_rd) && !launched) launched <= 1'b1;
      case (st)
        S_IDLE: if (req_valid) begin
          r0_q        <= (req_r0_word & ~R0_FORCE_CLR) | R0_FORCE_SET;
          res_core    <= '0;
          res_band    <= '0;
          res_bias    <= '0;
          res_timeout <= 1'b0;
          st          <= S_W10A;
        end
        S_W10A: if (eng_done) begin launched <= 1'b0; st <= S_W7A; end
        S_W7A:  if (eng_done) begin launched <= 1'b0; st <= S_W4;  end
        S_W4:   if (eng_done) begin launched <= 1'b0; st <= S_W0;  end
        S_W0:   if (eng_done) begin
          launched <= 1'b0;
          to_cnt   <= '0;
          st       <= S_WAIT;
        end
        S_WAIT: begin
          if (mux_s) begin
            st <= S_W7B;
          end else if (to_cnt == TW'(TIMEOUT_CYC - 1)) begin
            res_timeout <= 1'b1;
            st          <= S_OUT;
          end else begin
            to_cnt <= to_cnt + 1'b1;
          end
        end
        S_W7B: if (eng_done) begin launched <= 1'b0; st <= S_RD_CB; end
        S_RD_CB: if (eng_done) begin
          launched <= 1'b0;
          res_core <= rd_word[11:9];
          res_band <= rd_word[7:0];
          st       <= S_W10B;
        end
        S_W10B: if (eng_done) begin launched <= 1'b0; st <= S_RD_BIAS; end
        S_RD_BIAS: if (eng_done) begin
          launched <= 1'b0;
          res_bias <= rd_word[3:0];
          st       <= S_OUT;
        end
        S_OUT: if (res_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vco_cal_reader.sv
module vco_cal_reader
  import vco_cal_pkg::*;
#(
  parameter int HALF_CYC    = 5,
  parameter int TIMEOUT_CYC = 100000,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_r0_word,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [2:0]  res_core,
  output logic [7:0]  res_band,
  output logic [3:0]  res_bias,
  output logic        res_timeout,
  output logic        spi_sclk,
  output logic        spi_sdata,
  output logic        spi_le,
  input  logic        mux_in
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   mux_s;
  logic                   eng_done;
  logic                   start_wr;
  logic                   start_rd;
  logic [WORD_W-1:0]      wr_word;
  logic [RB_W-1:0]        rd_word;
  logic                   cal_wait;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= mux_in;
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], mux_in};
    end
  endgenerate
  assign mux_s = sync_q[SYNC_STAGES-1];

  vcr_serial_engine #(.HALF_CYC(HALF_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd),
    .wr_word(wr_word), .mux_s(mux_s), .done(eng_done), .rd_word(rd_word),
    .sclk(spi_sclk), .sdata(spi_sdata), .le(spi_le)
  );

  vcr_seq_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_r0_word(req_r0_word), .res_valid(res_valid), .res_ready(res_ready),
    .res_core(res_core), .res_band(res_band), .res_bias(res_bias),
    .res_timeout(res_timeout), .mux_s(mux_s), .eng_done(eng_done),
    .rd_word(rd_word), .start_wr(start_wr), .start_rd(start_rd),
    .wr_word(wr_word), .cal_wait(cal_wait)
  );
endmodule

// File: rtl/vco_cal_reader_chk.sv
module vco_cal_reader_chk #(
  parameter int HALF_CYC = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk,
  input logic       le,
  input logic       req_ready,
  input logic       res_valid,
  input logic       res_ready,
  input logic [2:0] res_core,
  input logic [7:0] res_band,
  input logic [3:0] res_bias,
  input logic       res_timeout,
  input logic       cal_wait
);
  logic        sclk_prev;
  logic [15:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      run_len   <= 16'hFFFF;
    end else begin
      sclk_prev <= sclk;
      if (sclk != sclk_prev)      run_len <= 16'd1;
      else if (run_len != 16'hFFFF) run_len <= run_len + 16'd1;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!le && !sclk));

  p_wait_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cal_wait |-> (!le && !sclk));

  p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_core) &&
      $stable(res_band) && $stable(res_bias) && $stable(res_timeout)));

  p_timeout_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_timeout) |-> (res_core == 3'd0 && res_band == 8'd0 &&
      res_bias == 4'd0));

  p_min_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != sclk_prev) |-> (run_len >= 16'(HALF_CYC)));
endmodule

bind vco_cal_reader vco_cal_reader_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .le(spi_le),
  .req_ready(req_ready), .res_valid(res_valid), .res_ready(res_ready),
  .res_core(res_core), .res_band(res_band), .res_bias(res_bias),
  .res_timeout(res_timeout), .cal_wait(cal_wait)
);

// File: tb/vco_cal_reader_bench.sv
`timescale 1ns/1ps
module vco_cal_reader_bench;
  localparam int HALF = 5;
  localparam int TMO  = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_r0_word = '0;
  logic res_valid;
  logic res_ready = 1'b0;
  logic [2:0] res_core;
  logic [7:0] res_band;
  logic [3:0] res_bias;
  logic res_timeout;
  logic spi_sclk, spi_sdata, spi_le;
  logic mux_in;

  always #2.5 clk = ~clk;

  vco_cal_reader #(.HALF_CYC(HALF), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2))
    u_vco_cal_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_r0_word(req_r0_word), .res_valid(res_valid), .res_ready(res_ready),
    .res_core(res_core), .res_band(res_band), .res_bias(res_bias),
    .res_timeout(res_timeout), .spi_sclk(spi_sclk), .spi_sdata(spi_sdata),
    .spi_le(spi_le), .mux_in(mux_in)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  // device model state
  logic [31:0] shreg = '0;
  int          nbits = 0;
  logic [31:0] log_w [0:255];
  int          log_n = 0;
  logic [2:0]  rdsel = 3'b000;
  logic [2:0]  rbsel = 3'b000;
  int          rdidx = 0;
  logic        rd_bit = 1'b0;
  logic        prev_le = 1'b0;
  logic        prev_sc = 1'b0;
  int          r0_cnt = 0;
  int          r0_seen = 0;
  int          cal_cnt = 0;
  logic        cal_done = 1'b0;
  int          cal_delay = 50;
  logic [2:0]  m_core = 3'd1;
  logic [7:0]  m_band = 8'd0;
  logic [3:0]  m_bias = 4'd0;
  logic [11:0] rdword;

  always_comb begin
    if (rdsel == 3'b001) rdword = {m_core, ~m_band[0], m_band};
    else                 rdword = {8'hA5 ^ m_band, m_bias};
  end

  assign mux_in = (rbsel == 3'b110) ? cal_done :
                  (rbsel == 3'b111 && spi_le) ? rd_bit : 1'b0;

  always @(spi_sclk or spi_le) begin
    if (spi_le != prev_le) begin
      if (spi_le) begin
        if (nbits == 32) begin
          log_w[log_n] = shreg;
          log_n++;
          case (shreg[3:0])
            4'd10: rdsel = shreg[28:26];
            4'd7:  rbsel = shreg[14:12];
            4'd0:  r0_cnt++;
            default: ;
          endcase
        end else if (nbits == 0) begin
          rdidx = 0;
        end
      end else begin
        nbits = 0;
      end
      prev_le = spi_le;
    end
    if (spi_sclk && !prev_sc) begin
      if (!spi_le) begin
        shreg = {shreg[30:0], spi_sdata};
        nbits++;
      end else if (rdidx < 12) begin
        rd_bit = rdword[11-rdidx];
        rdidx++;
      end
    end
    prev_sc = spi_sclk;
  end

  always @(posedge clk) begin
    if (r0_cnt != r0_seen) begin
      r0_seen = r0_cnt;
      cal_cnt = 0;
      cal_done <= 1'b0;
    end else if (cal_delay >= 0 && !cal_done) begin
      if (cal_cnt >= cal_delay) cal_done <= 1'b1;
      else cal_cnt++;
    end
  end

  // timing observation (R9)
  logic t_psc = 1'b0, t_ple = 1'b0;
  int run = 1000, min_run = 1000, le_t = 0, min_setup = 1000, first_rd = 0;
  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (spi_sclk != t_psc) begin
        if (run < min_run) min_run = run;
        run = 1;
      end else run++;
      if (spi_le && !t_ple) begin le_t = cyc; first_rd = 1; end
      if (spi_sclk && !t_psc && spi_le && first_rd == 1) begin
        if (cyc - le_t < min_setup) min_setup = cyc - le_t;
        first_rd = 0;
      end
      if (!spi_le) first_rd = 0;
      t_psc = spi_sclk;
      t_ple = spi_le;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  task automatic do_run(input logic [2:0] core, input logic [7:0] band,
                        input logic [3:0] bias, input int delay,
                        input logic [31:0] r0, input int hold);
    int base;
    int waited;
    logic [2:0] c0;
    logic [7:0] b0;
    logic [3:0] s0;
    m_core = core; m_band = band; m_bias = bias; cal_delay = delay;
    base = log_n;
    @(negedge clk);
    chk("R7 req_ready idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_r0_word = r0;
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!res_valid && waited < 20000) begin @(negedge clk); waited++; end
    chk("R7 result arrives", {31'd0, res_valid}, 32'd1);
    chk("R2 word0 R10 core/band", log_w[base],   (32'd1 << 26) | 32'd10);
    chk("R2 word1 R7 cal-done",   log_w[base+1], (32'd6 << 12) | 32'd7);
    chk("R2 word2 R4 mux",        log_w[base+2], (32'd7 << 27) | 32'd4);
    chk("R2 word3 R0 autocal",    log_w[base+3],
        (r0 & ~32'hF) | (32'd1 << 21));
    if (delay < 0) begin
      chk("R8 timeout flag", {31'd0, res_timeout}, 32'd1);
      chk("R8 zero fields", {17'd0, res_core, res_band, res_bias}, 32'd0);
      chk("R8 no further writes", log_n - base, 4);
    end else begin
      chk("R3 word count", log_n - base, 6);
      chk("R4 word4 R7 data",  log_w[base+4], (32'd7 << 12) | 32'd7);
      chk("R6 word5 R10 bias", log_w[base+5], (32'd3 << 26) | 32'd10);
      chk("R5 core", {29'd0, res_core}, {29'd0, core});
      chk("R5 band", {24'd0, res_band}, {24'd0, band});
      chk("R6 bias", {28'd0, res_bias}, {28'd0, bias});
      chk("R8 no timeout", {31'd0, res_timeout}, 32'd0);
    end
    c0 = res_core; b0 = res_band; s0 = res_bias;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R7 stall holds", {12'd0, res_valid, c0, b0, s0},
          {12'd0, 1'b1, res_core, res_band, res_bias});
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk("R7 released", {30'd0, res_valid, req_ready}, 32'd1);
  endtask

  initial begin
    int w = 0;
    while (w < 190000 && cyc < 190000) begin @(posedge clk); w++; end
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected <190000 cycles", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset lines", {28'd0, spi_le, spi_sclk, req_ready, res_valid},
        32'b0010);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {28'd0, spi_le, spi_sclk, req_ready, res_valid},
        32'b0010);
    for (int c = 1; c <= 4; c++) begin
      for (int b = 0; b < 4; b++) begin
        logic [7:0] bv;
        bv = 8'((b * 85) + (b == 3 ? 0 : 1) * (c - 1));
        do_run(3'(c), bv, 4'((c * 5 + b * 3) & 15), 20 + c * 37 + b * 11,
               32'hDEAD_BEE0 ^ (32'(c) << 8) ^ 32'(b * 7 + 5), (b % 3) * 4);
      end
    end
    do_run(3'd2, 8'd99, 4'd9, -1, 32'h1234_567F, 3);
    do_run(3'd4, 8'd255, 4'd15, 2500, 32'h0020_000A, 0);
    chk("R9 min level cycles", (min_run >= HALF) ? 32'd1 : 32'd0, 32'd1);
    chk("R9 le setup cycles", (min_setup >= HALF) ? 32'd1 : 32'd0, 32'd1);
    finish_run();
  end
endmodule